// File: doc/BRIEF.md
# GPIO Pin Event Detector with Interrupt

This block watches the resolved input vector of a 32-pin port and records events per pin. Each pin can be set to level mode or edge mode. In edge mode, the pin reacts either to rising edges only or to both edges. Detected events collect in a sticky status register. Software clears status bits by writing ones to them. A per-pin enable mask selects which status bits drive a single active-high interrupt line.

Software reaches the block through a simple 32-bit register bus. The bus has a write strobe, a byte address and write data. Read data is combinational from the address. The enable mask can be written whole, or changed through a set alias and a clear alias. This lets one pin be masked or unmasked without a read-modify-write. Pin resolution, debounce and the interrupt controller sit outside the block.

Top module: `gpio_evt_unit`

## Requirements
- R1: After reset, the type, both-edges, enable and status registers all read 0, and the interrupt is low.
- R2: Register map by byte address: type 0x28, both-edges 0x2C, enable 0x40, enable-set 0x44, enable-clear 0x48, status 0x4C. Type, both-edges and enable read back the value written. The two aliases and every other address read as 0. Writes to any other address change nothing.
- R3: A write to the enable-set alias ORs the one bits of the write data into enable and leaves the other bits unchanged.
- R4: A write to the enable-clear alias clears the enable bits where the write data has ones and leaves the other bits unchanged.
- R5: A pin whose type bit is 0 is in level mode. Its status bit is set at each clock edge where its input is 1. The bit stays set after the input returns to 0.
- R6: In level mode, a write of 1 to the status bit of a pin whose input is still 1 leaves that bit set.
- R7: A pin with type 1 and both-edges 0 sets its status bit on a 0-to-1 change of its input. A 1-to-0 change does not set it.
- R8: A pin with type 1 and both-edges 1 sets its status bit on any change of its input.
- R9: Writing to status clears exactly the bits written as 1. If an event hits the same bit in the same cycle as the clear, the bit stays set.
- R10: The interrupt is 1 exactly when any bit of (status AND enable) is 1. It therefore stays high after the input falls until the status bit is cleared or masked, and it is low while enable is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 8 | Register byte address |
| busWdata | input | 32 | Register write data |
| busRdata | output | 32 | Register read data, combinational from busAddr |
| pinIn | input | 32 | Resolved pin input vector |
| irqOut | output | 1 | Interrupt, high while any enabled status bit is set |

## Verification
Every register change lands on the clock edge that ends the write cycle. A status bit updates on the edge that closes the first cycle in which the changed input is present. Read data and the interrupt are combinational from the registers, so both are valid in the cycle right after that edge. The bench drives every input at the falling edge and samples one nanosecond later. Each result is therefore compared in the first cycle where it is due, against a model that advances on the same rising edge as the design.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_TYPE  = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_BOTH  = 8'h2C;
  localparam logic [ADDR_W-1:0] OFS_EN    = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_ENSET = 8'h44;
  localparam logic [ADDR_W-1:0] OFS_ENCLR = 8'h48;
  localparam logic [ADDR_W-1:0] OFS_STS   = 8'h4C;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_TYPE,
    RD_BOTH,
    RD_EN,
    RD_STS
  } rdSel_e;

  typedef struct packed {
    logic wrType;
    logic wrBoth;
    logic wrEn;
    logic wrEnSet;
    logic wrEnClr;
    logic wrSts;
  } wrStrobe_t;

endpackage

// File: rtl/gpio_evt_ctrl.sv
module gpio_evt_ctrl
  import gpio_evt_pkg::*;
(
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output wrStrobe_t         strobes,
  output rdSel_e            rdSel
);

  always_comb begin
    strobes = '0;
    if (busWe) begin
      unique case (busAddr)
        OFS_TYPE:  strobes.wrType  = 1'b1;
        OFS_BOTH:  strobes.wrBoth  = 1'b1;
        OFS_EN:    strobes.wrEn    = 1'b1;
        OFS_ENSET: strobes.wrEnSet = 1'b1;
        OFS_ENCLR: strobes.wrEnClr = 1'b1;
        OFS_STS:   strobes.wrSts   = 1'b1;
        default:   strobes = '0;
      endcase
    end
  end

  always_comb begin
    unique case (busAddr)
      OFS_TYPE: rdSel = RD_TYPE;
      OFS_BOTH: rdSel = RD_BOTH;
      OFS_EN:   rdSel = RD_EN;
      OFS_STS:  rdSel = RD_STS;
      default:  rdSel = RD_NONE;
    endcase
  end

endmodule

// File: rtl/gpio_evt_dp.sv
module gpio_evt_dp
  import gpio_evt_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  wrStrobe_t           strobes,
  input  rdSel_e              rdSel,
  input  logic [NUM_PINS-1:0] wrData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] rdData,
  output logic                irqOut
);

  logic [NUM_PINS-1:0] typeQ;
  logic [NUM_PINS-1:0] bothQ;
  logic [NUM_PINS-1:0] enQ;
  logic [NUM_PINS-1:0] stsQ;
  logic [NUM_PINS-1:0] prevQ;
  logic [NUM_PINS-1:0] hit;
  logic [NUM_PINS-1:0] clrMask;
  logic [NUM_PINS-1:0] fallOnly;

  // previous-input copy tracks the pins every cycle, including during reset
  always_ff @(posedge clk) begin
    prevQ <= pinIn;
  end

  for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_pin
    logic riseEdge;
    logic fallEdge;
    assign riseEdge = pinIn[gi] & ~prevQ[gi];
    assign fallEdge = ~pinIn[gi] & prevQ[gi];
    assign hit[gi]  = typeQ[gi] ? (riseEdge | (bothQ[gi] & fallEdge)) : pinIn[gi];
  end

  assign clrMask  = strobes.wrSts ? wrData : '0;
  assign fallOnly = typeQ & ~bothQ & prevQ & ~pinIn & ~stsQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      typeQ <= '0;
      bothQ <= '0;
      enQ   <= '0;
      stsQ  <= '0;
    end else begin
      if (strobes.wrType) typeQ <= wrData;
      if (strobes.wrBoth) bothQ <= wrData;
      if (strobes.wrEn)         enQ <= wrData;
      else if (strobes.wrEnSet) enQ <= enQ | wrData;
      else if (strobes.wrEnClr) enQ <= enQ & ~wrData;
      stsQ <= (stsQ & ~clrMask) | hit;
    end
  end

  assign irqOut = |(stsQ & enQ);

  always_comb begin
    unique case (rdSel)
      RD_TYPE: rdData = typeQ;
      RD_BOTH: rdData = bothQ;
      RD_EN:   rdData = enQ;
      RD_STS:  rdData = stsQ;
      default: rdData = '0;
    endcase
  end

  // R5
  sticky_sts_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrSts |=> ((stsQ & $past(stsQ)) == $past(stsQ)));

  // R6
  lvl_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrSts |=> ((stsQ & $past(wrData & ~typeQ & pinIn)) == $past(wrData & ~typeQ & pinIn)));

  // R7
  rise_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|fallOnly) |=> ((stsQ & $past(fallOnly)) == '0));

  // R3
  en_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrEnSet |=> ((enQ & $past(wrData)) == $past(wrData)));

  // R4
  en_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrEnClr |=> ((enQ & $past(wrData)) == '0));

  // R10
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enQ == '0) |-> !irqOut);

endmodule

// File: rtl/gpio_evt_unit.sv
module gpio_evt_unit
  import gpio_evt_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWe,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [NUM_PINS-1:0] busWdata,
  output logic [NUM_PINS-1:0] busRdata,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic                irqOut
);

  wrStrobe_t strobes;
  rdSel_e    rdSel;

  gpio_evt_ctrl u_ctrl (
    .busWe   (busWe),
    .busAddr (busAddr),
    .strobes (strobes),
    .rdSel   (rdSel)
  );

  gpio_evt_dp #(.NUM_PINS(NUM_PINS)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .rdSel   (rdSel),
    .wrData  (busWdata),
    .pinIn   (pinIn),
    .rdData  (busRdata),
    .irqOut  (irqOut)
  );

endmodule

// File: tb/gpio_evt_unit_tb.sv
`timescale 1ns/1ps
module gpio_evt_unit_tb;

  localparam logic [7:0] A_TYPE  = 8'h28;
  localparam logic [7:0] A_BOTH  = 8'h2C;
  localparam logic [7:0] A_EN    = 8'h40;
  localparam logic [7:0] A_ENSET = 8'h44;
  localparam logic [7:0] A_ENCLR = 8'h48;
  localparam logic [7:0] A_STS   = 8'h4C;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] pinIn = '0;
  logic        irqOut;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [31:0] mType = '0, mBoth = '0, mEn = '0, mSts = '0, mPrev = '0, mPin = '0;
  logic [31:0] lastRd;

  always #2.5 clk = ~clk;

  gpio_evt_unit u_dut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn), .irqOut(irqOut)
  );

  function automatic logic [31:0] rdModel(input logic [7:0] a);
    case (a)
      A_TYPE:  return mType;
      A_BOTH:  return mBoth;
      A_EN:    return mEn;
      A_STS:   return mSts;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic [7:0] addr, input logic [31:0] wd);
    logic [31:0] hitV, clrV;
    @(negedge clk);
    busWe = we; busAddr = addr; busWdata = wd; pinIn = mPin;
    #1;
    lastRd = busRdata;
    check(irqOut == (|(mSts & mEn)), "R10 irq vs status&enable", {31'b0, irqOut}, {31'b0, |(mSts & mEn)});
    if (!we) check(busRdata == rdModel(addr), "R2 read data vs model", busRdata, rdModel(addr));
    hitV = (~mType & mPin) | (mType & ((mPin & ~mPrev) | (mBoth & ~mPin & mPrev)));
    clrV = (we && addr == A_STS) ? wd : 32'h0;
    @(posedge clk);
    mSts = (mSts & ~clrV) | hitV;
    if (we) begin
      case (addr)
        A_TYPE:  mType = wd;
        A_BOTH:  mBoth = wd;
        A_EN:    mEn = wd;
        A_ENSET: mEn = mEn | wd;
        A_ENCLR: mEn = mEn & ~wd;
        default: ;
      endcase
    end
    mPrev = mPin;
  endtask

  task automatic rdExp(input logic [7:0] addr, input logic [31:0] exp, input string tag);
    cyc(1'b0, addr, 32'h0);
    check(lastRd == exp, tag, lastRd, exp);
  endtask

  task automatic irqExp(input logic exp, input string tag);
    #1;
    check(irqOut == exp, tag, {31'b0, irqOut}, {31'b0, exp});
  endtask

  initial begin
    #200000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    irqExp(1'b0, "R1 irq after reset");
    rdExp(A_TYPE, 32'h0, "R1 type reset");
    rdExp(A_BOTH, 32'h0, "R1 both reset");
    rdExp(A_EN,   32'h0, "R1 enable reset");
    rdExp(A_STS,  32'h0, "R1 status reset");
    // R2 read-back, aliases, unmapped
    cyc(1'b1, A_TYPE, 32'h0f0f0f0f);
    rdExp(A_TYPE, 32'h0f0f0f0f, "R2 type readback");
    cyc(1'b1, A_BOTH, 32'h33333333);
    rdExp(A_BOTH, 32'h33333333, "R2 both readback");
    cyc(1'b1, 8'h00, 32'hffffffff);
    rdExp(8'h00, 32'h0, "R2 unmapped reads 0");
    cyc(1'b1, A_TYPE, 32'h0);
    cyc(1'b1, A_BOTH, 32'h0);
    // R5 level mode, sticky
    mPin = 32'hba987654;
    cyc(1'b0, 8'h00, 32'h0);
    rdExp(A_STS, 32'hba987654, "R5 level status set");
    mPin = 32'h0;
    cyc(1'b0, 8'h00, 32'h0);
    rdExp(A_STS, 32'hba987654, "R5 level status sticky");
    irqExp(1'b0, "R10 irq low with enable 0");
    // R9 partial clear
    cyc(1'b1, A_STS, 32'h00007654);
    rdExp(A_STS, 32'hba980000, "R9 write-one clear");
    // R6 clear blocked while high
    mPin = 32'h00010000;
    cyc(1'b1, A_STS, 32'hffffffff);
    rdExp(A_STS, 32'h00010000, "R6 level clear blocked");
    mPin = 32'h0;
    cyc(1'b1, A_STS, 32'hffffffff);
    rdExp(A_STS, 32'h0, "R9 clear after input low");
    // R3 R4 R10 enable and interrupt
    mPin = 32'h00008000;
    cyc(1'b0, 8'h00, 32'h0);
    mPin = 32'h0;
    cyc(1'b0, 8'h00, 32'h0);
    irqExp(1'b0, "R10 masked event");
    cyc(1'b1, A_ENSET, 32'h00008000);
    irqExp(1'b1, "R3 unmask raises irq");
    cyc(1'b1, A_ENCLR, 32'h00008000);
    irqExp(1'b0, "R4 mask drops irq");
    cyc(1'b1, A_ENSET, 32'h00008000);
    irqExp(1'b1, "R3 unmask again");
    cyc(1'b1, A_ENSET, 32'h00000100);
    rdExp(A_EN, 32'h00008100, "R3 set alias ORs");
    rdExp(A_ENSET, 32'h0, "R2 set alias reads 0");
    irqExp(1'b1, "R10 irq held after input low");
    cyc(1'b1, A_STS, 32'h00008000);
    irqExp(1'b0, "R10 irq drops on status clear");
    cyc(1'b1, A_EN, 32'h0);
    // R7 rising only
    cyc(1'b1, A_TYPE, 32'hffffffff);
    cyc(1'b1, A_BOTH, 32'h0);
    mPin = 32'h0000ffff;
    cyc(1'b0, 8'h00, 32'h0);
    rdExp(A_STS, 32'h0000ffff, "R7 rising sets");
    cyc(1'b1, A_STS, 32'hffffffff);
    rdExp(A_STS, 32'h0, "R9 edge status cleared");
    mPin = 32'h00ff00ff;
    cyc(1'b0, 8'h00, 32'h0);
    rdExp(A_STS, 32'h00ff0000, "R7 falling ignored");
    // R8 both edges
    cyc(1'b1, A_BOTH, 32'hffffffff);
    cyc(1'b1, A_STS, 32'hffffffff);
    rdExp(A_STS, 32'h0, "R8 cleared before test");
    mPin = 32'h0f0f0f0f;
    cyc(1'b0, 8'h00, 32'h0);
    rdExp(A_STS, 32'h0ff00ff0, "R8 both edges set");
    // random phase checked against the model
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] a;
      logic [31:0] wd;
      int sel;
      sel = $urandom_range(0, 6);
      case (sel)
        0: a = A_TYPE; 1: a = A_BOTH; 2: a = A_EN; 3: a = A_ENSET;
        4: a = A_ENCLR; 5: a = A_STS; default: a = 8'h10;
      endcase
      wd = ($urandom_range(0, 3) == 0) ? 32'hffffffff : $urandom;
      if ($urandom_range(0, 3) == 0) mPin = mPin ^ $urandom;
      cyc($urandom_range(0, 1) == 1, a, wd);
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule